// File: doc/BRIEF.md
# Multi-Chip Channel Readout Sequencer

This block schedules the readout of a group of front-end chips. Each chip holds eight data channels and one test channel, and each channel has two buffers. The sequencer addresses one (chip, channel, buffer) location at a time with a single-cycle read request. It waits for the response word, then decides from the status field in that word where to read next. Data words are forwarded to one output stream, tagged with the chip and channel they came from.

A channel is read repeatedly until it returns an empty word. The sequencer then moves on to the next channel. A busy word means the buffer is still being filled, so the same location is requested again. A channel that stays busy for too long is abandoned. For each chip the block counts how many channels were closed by an empty word. When the last data channel of a chip is closed with fewer than eight such closures, the block emits a chip-full marker word. Chips are visited in a fixed rotating order. The buffer index toggles on every full rotation.

Top module: `readout_seq`

## Requirements
- R1: Words are 23 bits, with status in bits [22:20] and payload in bits [19:0]. Status bit 22 = 0 marks a data word (000 normal, 001 last word of a buffer). A data word is output unchanged with `out_valid` high for one cycle, one cycle after the response, with `out_chip`/`out_chan` equal to the location read.
- R2: Within a chip, channels are requested in order 0 to 7. Channel index 8 (test channel) is never requested. After channel 7 the next chip is requested, in order 0, 1, 2, 3, then 0 again.
- R3: After a data response the same location is requested again. A response with status 10x (empty) closes the channel and moves to the next one.
- R4: The per-chip count of empty closures starts at 0 for every chip. It is not carried across chips.
- R5: When channel 7 is closed (by empty or by busy timeout) and fewer than 8 channels of that chip were closed by empty, a marker is output. The marker has status 010, bits [19:0] copied from the closing response, `out_chip` equal to the chip and `out_chan` = 7. With 8 empty closures, nothing is output.
- R6: A response with status 11x (busy) is not output and the same location is requested again. The 16th consecutive busy response on one location closes the channel without counting it as empty. 15 busy responses followed by data do not close it.
- R7: `rd_buf` is 0 after reset and toggles each time the chip index wraps from 3 to 0.
- R8: After reset `rd_req` and `out_valid` are low, and the first request is chip 0, channel 0, buffer 0. At most one request is outstanding, and `rd_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | output | 1 | One-cycle read request for the addressed location |
| rd_chip | output | 2 | Chip index of the request |
| rd_chan | output | 4 | Channel index of the request (0..7) |
| rd_buf | output | 1 | Buffer index of the request |
| rsp_valid | input | 1 | Response word is valid this cycle |
| rsp_word | input | 23 | Response word, status in [22:20] |
| out_valid | output | 1 | Output word valid (one cycle) |
| out_word | output | 23 | Forwarded data word or chip-full marker |
| out_chip | output | 2 | Chip the output word belongs to |
| out_chan | output | 4 | Channel the output word belongs to |

## Verification
The hardest situation to reach is a chip-full marker. It needs a channel to give up after exactly sixteen consecutive busy responses, and the marker then appears only when channel 7 of that chip closes, which may be several channels later. The stimulus is a reactive responder that scripts per-location busy runs and data counts by sweep. It places one sixteen-busy timeout on channel 7 and another on channel 0 of a different chip, and a run of fifteen busy responses that must not time out. Response latency varies from zero to two cycles, and the responder predicts every requested address and every output word independently.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] ST_CHIPFULL = 3'b010;
  typedef enum logic [1:0] {K_DATA, K_EMPTY, K_BUSY} kind_t;
endpackage

// File: rtl/rsp_classify.sv
module rsp_classify
  import readout_pkg::*;
#(
  parameter int WORD_W = 23
) (
  input  logic [WORD_W-1:0] word,
  output kind_t             kind
);
  logic [STAT_W-1:0] st;
  assign st = word[WORD_W-1 -: STAT_W];

  always_comb begin
    if (!st[2])     kind = K_DATA;
    else if (st[1]) kind = K_BUSY;
    else            kind = K_EMPTY;
  end
endmodule

// File: rtl/busy_guard.sv
module busy_guard #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic expire
);
  localparam int BW = $clog2(LIMIT + 1);
  logic [BW-1:0] run_q;

  assign expire = hit && (run_q == BW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (clr)    run_q <= '0;
    else if (expire) run_q <= '0;
    else if (hit)    run_q <= run_q + 1'b1;
  end

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (rst)
    run_q < BW'(LIMIT));
  assert_busy_reset_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> run_q == '0);
endmodule

// File: rtl/drain_judge.sv
module drain_judge #(
  parameter int DATA_CH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tally,
  input  logic chip_end,
  output logic chip_full
);
  localparam int CW = $clog2(DATA_CH + 1);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   fin;

  assign fin       = {1'b0, cnt_q} + (CW+1)'(tally);
  assign chip_full = fin < (CW+1)'(DATA_CH);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (chip_end) cnt_q <= '0;
    else if (tally)    cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (rst)
    chip_end |=> cnt_q == '0);
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DATA_CH));
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import readout_pkg::*;
#(
  parameter int N_CHIP     = 4,
  parameter int DATA_CH    = 8,
  parameter int BUSY_LIMIT = 16,
  parameter int WORD_W     = 23,
  localparam int CHIP_W    = (N_CHIP > 1) ? $clog2(N_CHIP) : 1,
  localparam int CHAN_W    = $clog2(DATA_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              rd_req,
  output logic [CHIP_W-1:0] rd_chip,
  output logic [CHAN_W-1:0] rd_chan,
  output logic              rd_buf,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [CHIP_W-1:0] out_chip,
  output logic [CHAN_W-1:0] out_chan
);
  localparam int PAY_W = WORD_W - STAT_W;

  logic              pend_q, req_q, buf_q;
  logic [CHIP_W-1:0] chip_q;
  logic [CHAN_W-1:0] chan_q;
  logic              ov_q;
  logic [WORD_W-1:0] ow_q;
  logic [CHIP_W-1:0] oc_q;
  logic [CHAN_W-1:0] och_q;

  kind_t kind;
  logic  take, is_data, is_empty, is_busy, expire, advance;
  logic  last_ch, last_chip, chip_end, chip_full;

  rsp_classify #(.WORD_W(WORD_W)) u_cls (.word(rsp_word), .kind(kind));

  assign take      = pend_q && rsp_valid;
  assign is_data   = take && (kind == K_DATA);
  assign is_empty  = take && (kind == K_EMPTY);
  assign is_busy   = take && (kind == K_BUSY);
  assign advance   = is_empty || expire;
  assign last_ch   = chan_q == CHAN_W'(DATA_CH - 1);
  assign last_chip = chip_q == CHIP_W'(N_CHIP - 1);
  assign chip_end  = advance && last_ch;

  busy_guard #(.LIMIT(BUSY_LIMIT)) u_busy (
    .clk(clk), .rst(rst), .clr(is_data || is_empty), .hit(is_busy), .expire(expire)
  );

  drain_judge #(.DATA_CH(DATA_CH)) u_drain (
    .clk(clk), .rst(rst), .tally(is_empty), .chip_end(chip_end), .chip_full(chip_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      buf_q  <= 1'b0;
      chip_q <= '0;
      chan_q <= '0;
      ov_q   <= 1'b0;
      ow_q   <= '0;
      oc_q   <= '0;
      och_q  <= '0;
    end else begin
      req_q <= 1'b0;
      ov_q  <= 1'b0;
      if (!pend_q) begin
        req_q  <= 1'b1;
        pend_q <= 1'b1;
      end else if (rsp_valid) begin
        pend_q <= 1'b0;
      end
      if (is_data) begin
        ov_q  <= 1'b1;
        ow_q  <= rsp_word;
        oc_q  <= chip_q;
        och_q <= chan_q;
      end
      if (chip_end && chip_full) begin
        ov_q  <= 1'b1;
        ow_q  <= {ST_CHIPFULL, rsp_word[PAY_W-1:0]};
        oc_q  <= chip_q;
        och_q <= chan_q;
      end
      if (advance) begin
        if (last_ch) begin
          chan_q <= '0;
          if (last_chip) begin
            chip_q <= '0;
            buf_q  <= ~buf_q;
          end else begin
            chip_q <= chip_q + 1'b1;
          end
        end else begin
          chan_q <= chan_q + 1'b1;
        end
      end
    end
  end

  assign rd_req    = req_q;
  assign rd_chip   = chip_q;
  assign rd_chan   = chan_q;
  assign rd_buf    = buf_q;
  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign out_chip  = oc_q;
  assign out_chan  = och_q;

  assert_single_req_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  assert_no_test_chan_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_chan < CHAN_W'(DATA_CH));
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !rsp_valid) |=> ($stable(rd_chip) && $stable(rd_chan) && $stable(rd_buf)));
  assert_buf_flip_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_buf) |-> (rd_chip == '0 && $past(rd_chip) == CHIP_W'(N_CHIP - 1)));
  assert_out_cause_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(take));
endmodule

// File: tb/readout_seq_bench.sv
`timescale 1ns/1ps
module readout_seq_bench;
  typedef struct {
    logic [22:0] w;
    logic [1:0]  c;
    logic [3:0]  ch;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req, rd_buf, out_valid;
  logic [1:0]  rd_chip, out_chip;
  logic [3:0]  rd_chan, out_chan;
  logic        rsp_valid = 1'b0;
  logic [22:0] rsp_word = '0;
  logic [22:0] out_word;

  int errors = 0, checks = 0;
  int markers_exp = 0, markers_seen = 0;
  bit done = 1'b0, finished = 1'b0;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  readout_seq u_readout_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_chip(rd_chip), .rd_chan(rd_chan),
    .rd_buf(rd_buf), .rsp_valid(rsp_valid), .rsp_word(rsp_word), .out_valid(out_valid),
    .out_word(out_word), .out_chip(out_chip), .out_chan(out_chan)
  );

  function automatic int n_data(int s, int c, int h);
    return (s * 3 + c * 5 + h) % 4;
  endfunction

  function automatic int n_busy(int s, int c, int h);
    if (s == 0 && c == 1 && h == 7) return 16;
    if (s == 1 && c == 3 && h == 0) return 16;
    if (s == 1 && c == 0 && h == 2) return 15;
    if (c == 2 && h == 3) return 3;
    return 0;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reset state, R8
  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (rd_req !== 1'b0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset state: rd_req=%b out_valid=%b expected 0 0", rd_req, out_valid);
    end
    rst = 1'b0;
  end

  // driver / responder: predicts request addresses and pushes expected outputs
  initial begin : driver
    int e_chip = 0, e_chan = 0, e_cnt = 0, run = 0, sweep = 0, nreq = 0;
    int vb = 0, vd = 0;
    logic e_buf = 1'b0;
    logic [22:0] word;
    logic [19:0] pay;
    int kind;
    exp_t x;
    wait (!rst);
    while (sweep < 3) begin
      @(negedge clk);
      if (rd_req) begin
        checks++;
        if (rd_chip !== 2'(e_chip) || rd_chan !== 4'(e_chan) || rd_buf !== e_buf) begin
          errors++;
          $display("FAIL R2,R3,R6,R7 request addr: got chip=%0d chan=%0d buf=%0d expected %0d %0d %0d",
                   rd_chip, rd_chan, rd_buf, e_chip, e_chan, e_buf);
        end
        pay = 20'(nreq * 977 + e_chip * 131 + e_chan * 17 + 5);
        if (vb < n_busy(sweep, e_chip, e_chan)) begin
          word = {3'b110, pay}; kind = 2; vb++;
        end else if (vd < n_data(sweep, e_chip, e_chan)) begin
          word = {(vd == n_data(sweep, e_chip, e_chan) - 1) ? 3'b001 : 3'b000, pay};
          kind = 0; vd++;
          x.w = word; x.c = 2'(e_chip); x.ch = 4'(e_chan);
          sbq.push_back(x);
        end else begin
          word = {3'b100, pay}; kind = 1;
        end
        if (kind == 0) run = 0;
        else begin
          if (kind == 1) e_cnt++;
          else run++;
          if (kind == 1 || run == 16) begin
            run = 0; vb = 0; vd = 0;
            if (e_chan == 7) begin
              if (e_cnt < 8) begin
                x.w = {3'b010, word[19:0]}; x.c = 2'(e_chip); x.ch = 4'd7;
                sbq.push_back(x);
                markers_exp++;
              end
              e_cnt = 0; e_chan = 0;
              if (e_chip == 3) begin e_chip = 0; e_buf = ~e_buf; sweep++; end
              else e_chip++;
            end else e_chan++;
          end
        end
        repeat (nreq % 3) @(negedge clk);
        rsp_valid = 1'b1; rsp_word = word;
        @(negedge clk);
        rsp_valid = 1'b0;
        nreq++;
      end
    end
    repeat (20) @(negedge clk);
    done = 1'b1;
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R1,R5 pending outputs: got %0d missing expected 0", sbq.size());
    end
    checks++;
    if (markers_seen != markers_exp || markers_exp != 2) begin
      errors++;
      $display("FAIL R4,R5 marker count: got %0d expected %0d (plan 2)", markers_seen, markers_exp);
    end
    summary();
  end

  // monitor: scoreboard compare and request spacing (R8)
  initial begin : monitor
    logic prev_req = 1'b0;
    exp_t x;
    forever begin
      @(negedge clk);
      if (!rst && rd_req) begin
        checks++;
        if (prev_req) begin
          errors++;
          $display("FAIL R8 back-to-back request: got 1 expected 0");
        end
      end
      prev_req = rd_req;
      if (!rst && out_valid) begin
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R1,R6 unexpected output: got %h expected none", out_word);
        end else begin
          x = sbq.pop_front();
          if (x.w[22:20] == 3'b010) markers_seen++;
          if (out_word !== x.w || out_chip !== x.c || out_chan !== x.ch) begin
            errors++;
            $display("FAIL %s output: got %h chip=%0d chan=%0d expected %h chip=%0d chan=%0d",
                     (x.w[22:20] == 3'b010) ? "R5" : "R1",
                     out_word, out_chip, out_chan, x.w, x.c, x.ch);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    summary();
  end
endmodule